// File: doc/BRIEF.md
# Power-Fail Chip-Enable Conditioner

This block sits between a host's active-low memory chip enable and a battery-backed static RAM. While the supply is in tolerance it passes the host enable through a single output register. When a digitized power-fail flag indicates that the supply has dropped, it blocks any new access. An access that is already running may finish, but only within a bounded write-protect window; after that the enable is forced inactive. A threshold-select bit chooses which of two power-fail comparator flags is used.

When the supply comes back, the conditioned enable is held inactive for a fixed recovery interval before host accesses are passed again. A separate battery-select output tells the supply switch to feed the memory from the backup cell while the supply sits below the switchover level. All three comparator flags are resynchronized with two flops before use. Both intervals are counted in clock cycles and set by parameters.

Top module: `pfce_conditioner`

## Requirements
- R1: While the block is in normal operation and no power fail is seen, `mem_ce_n` equals the value `host_ce_n` had at the previous rising clock edge.
- R2: With `thr_sel` = 0 only `fail_hi` (the higher threshold) signals power fail; with `thr_sel` = 1 only `fail_lo` (the lower threshold) does. The unselected flag has no effect on `mem_ce_n`.
- R3: A change on a comparator flag takes effect at the third rising clock edge after it is applied, after two synchronizer stages.
- R4: Once power fail is seen with `host_ce_n` high, `mem_ce_n` is 1 and stays 1 whatever `host_ce_n` does.
- R5: If `host_ce_n` is low when power fail is seen, `mem_ce_n` stays low until the host raises `host_ce_n`; from then on it stays 1 even if the host drives it low again.
- R6: An access that is still running after `WP_CYCLES` clock cycles of power fail is cut off: `mem_ce_n` goes to 1 at that edge and stays 1.
- R7: `bat_sel` is 1 from the third rising edge after `below_sw` rises and returns to 0 at the third rising edge after it falls.
- R8: After the selected power-fail flag clears, `mem_ce_n` stays 1 for `REC_CYCLES` cycles beyond the synchronizer delay, then follows the host again.
- R9: Synchronous active-high `rst` sets `mem_ce_n` to 1 and `bat_sel` to 0 and starts a full recovery interval: `mem_ce_n` follows the host only from the `REC_CYCLES`-th rising edge after reset is released.
- R10: A power fail seen during the recovery interval, including on its very last cycle, cancels it; a full new interval starts after the flag clears again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ce_n | input | 1 | Active-low chip enable from the host |
| thr_sel | input | 1 | 0 selects the higher power-fail threshold, 1 selects the lower |
| fail_hi | input | 1 | Asynchronous flag: supply below the higher threshold |
| fail_lo | input | 1 | Asynchronous flag: supply below the lower threshold |
| below_sw | input | 1 | Asynchronous flag: supply below the battery switchover level |
| mem_ce_n | output | 1 | Conditioned active-low chip enable to the memory |
| bat_sel | output | 1 | 1 selects the battery as the memory supply |

## Verification
The recovery counter completing and a fresh power fail arriving can fall on the same clock edge. The bench provokes this by clearing the flag, waiting exactly the recovery length, and then raising the flag again, so that the synchronized fail reaches the controller on the edge where recovery would end. The case passes only if `mem_ce_n` stays 1 through that edge and a complete new recovery interval follows once the flag clears. The write-protect expiry is also timed to the edge, with the output checked one cycle before and at the cutoff.

// File: rtl/pfce_pkg.sv
package pfce_pkg;

    typedef enum logic [1:0] {
        PF_RECOVER = 2'd0,
        PF_ACTIVE  = 2'd1,
        PF_DRAIN   = 2'd2,
        PF_LOCKED  = 2'd3
    } pf_state_e;

    typedef struct packed {
        logic fail_hi;
        logic fail_lo;
        logic below_sw;
    } pf_flags_t;

    localparam int unsigned PF_FLAG_W = $bits(pf_flags_t);

    function automatic logic pf_pick_fail(input pf_flags_t f, input logic thr);
        return thr ? f.fail_lo : f.fail_hi;
    endfunction

    function automatic int unsigned pf_cnt_width(input int unsigned limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/pfce_sync.sv
module pfce_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pfce_timer.sv
module pfce_timer #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    import pfce_pkg::*;
    localparam int unsigned CW   = pf_cnt_width(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt <= '0;
        else if (!done)   cnt <= cnt + 1'b1;
    end

    // R6 R8
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R6 R8
    idle_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));
endmodule

// File: rtl/pfce_ctrl.sv
module pfce_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic host_ce_n,
    input  logic fail,
    input  logic wp_done,
    input  logic rec_done,
    output logic wp_run,
    output logic rec_run,
    output logic mem_ce_n
);
    import pfce_pkg::*;

    pf_state_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            PF_RECOVER: begin
                if (fail)          nxt = PF_LOCKED;
                else if (rec_done) nxt = PF_ACTIVE;
            end
            PF_ACTIVE: begin
                if (fail) nxt = host_ce_n ? PF_LOCKED : PF_DRAIN;
            end
            PF_DRAIN: begin
                if (host_ce_n || wp_done) nxt = PF_LOCKED;
            end
            PF_LOCKED: begin
                if (!fail) nxt = PF_RECOVER;
            end
            default: nxt = PF_LOCKED;
        endcase
    end

    assign wp_run  = (state == PF_DRAIN);
    assign rec_run = (state == PF_RECOVER);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PF_RECOVER;
            mem_ce_n <= 1'b1;
        end else begin
            state    <= nxt;
            mem_ce_n <= (nxt == PF_ACTIVE || nxt == PF_DRAIN) ? host_ce_n : 1'b1;
        end
    end

    // R1
    follow_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PF_ACTIVE && !fail) |=> (mem_ce_n == $past(host_ce_n)));

    // R4
    idle_block_chk: assert property (@(posedge clk) disable iff (rst)
        (fail && host_ce_n) |=> mem_ce_n);

    // R5
    drain_active_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PF_DRAIN) |-> !mem_ce_n);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PF_RECOVER || state == PF_LOCKED) |-> mem_ce_n);

    // R10
    cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PF_RECOVER && fail) |=> (state == PF_LOCKED));
endmodule

// File: rtl/pfce_conditioner.sv
module pfce_conditioner #(
    parameter int unsigned WP_CYCLES  = 12,
    parameter int unsigned REC_CYCLES = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic host_ce_n,
    input  logic thr_sel,
    input  logic fail_hi,
    input  logic fail_lo,
    input  logic below_sw,
    output logic mem_ce_n,
    output logic bat_sel
);
    import pfce_pkg::*;

    pf_flags_t flags_raw, flags_s;
    logic      fail_sel, wp_run, rec_run, wp_done, rec_done;

    assign flags_raw = '{fail_hi: fail_hi, fail_lo: fail_lo, below_sw: below_sw};

    pfce_sync #(.W(PF_FLAG_W), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (flags_raw),
        .q   (flags_s)
    );

    assign fail_sel = pf_pick_fail(flags_s, thr_sel);

    pfce_timer #(.LIMIT(WP_CYCLES)) u_wp_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (wp_run),
        .done (wp_done)
    );

    pfce_timer #(.LIMIT(REC_CYCLES)) u_rec_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (rec_run),
        .done (rec_done)
    );

    pfce_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .host_ce_n (host_ce_n),
        .fail      (fail_sel),
        .wp_done   (wp_done),
        .rec_done  (rec_done),
        .wp_run    (wp_run),
        .rec_run   (rec_run),
        .mem_ce_n  (mem_ce_n)
    );

    always_ff @(posedge clk) begin
        if (rst) bat_sel <= 1'b0;
        else     bat_sel <= flags_s.below_sw;
    end

    // R7
    bat_on_chk: assert property (@(posedge clk) disable iff (rst)
        flags_s.below_sw |=> bat_sel);

    // R7
    bat_off_chk: assert property (@(posedge clk) disable iff (rst)
        !flags_s.below_sw |=> !bat_sel);

    // R9
    initial begin
        wp_limit_chk: assert (WP_CYCLES >= 2 && REC_CYCLES >= 2);
    end
endmodule

// File: tb/tb_pfce_conditioner.sv
module tb_pfce_conditioner;
    localparam int WP  = 8;
    localparam int REC = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_ce_n = 1'b1, thr_sel = 1'b0;
    logic fail_hi = 1'b0, fail_lo = 1'b0, below_sw = 1'b0;
    logic mem_ce_n, bat_sel;

    int checks = 0;
    int errors = 0;

    pfce_conditioner #(.WP_CYCLES(WP), .REC_CYCLES(REC)) dut (
        .clk(clk), .rst(rst), .host_ce_n(host_ce_n), .thr_sel(thr_sel),
        .fail_hi(fail_hi), .fail_lo(fail_lo), .below_sw(below_sw),
        .mem_ce_n(mem_ce_n), .bat_sel(bat_sel)
    );

    always #4ns clk = ~clk;

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Flags cleared at a negedge; controller unlocks on edge 3, recovery ends on edge 3+REC.
    task automatic recover_check(input string req);
        fail_hi = 1'b0; fail_lo = 1'b0; host_ce_n = 1'b0;
        step(2 + REC);
        chk({req, " held during recovery"}, mem_ce_n, 1'b1);
        step(1);
        chk({req, " follows after recovery"}, mem_ce_n, 1'b0);
        host_ce_n = 1'b1;
        step(1);
    endtask

    task automatic t_reset;
        rst = 1'b1; host_ce_n = 1'b0;
        step(3);
        chk("R9 reset mem_ce_n", mem_ce_n, 1'b1);
        chk("R9 reset bat_sel", bat_sel, 1'b0);
        rst = 1'b0;
        step(REC - 1);
        chk("R9 held until interval end", mem_ce_n, 1'b1);
        step(1);
        chk("R9 follows after interval", mem_ce_n, 1'b0);
        host_ce_n = 1'b1;
        step(1);
    endtask

    task automatic t_follow;
        logic [7:0] pat = 8'b1001_0110;
        for (int i = 0; i < 8; i++) begin
            host_ce_n = pat[i];
            step(1);
            chk("R1 follow host", mem_ce_n, pat[i]);
        end
        host_ce_n = 1'b1;
        step(1);
    endtask

    task automatic t_thresh;
        thr_sel = 1'b0; fail_lo = 1'b1; host_ce_n = 1'b1;
        step(3);
        host_ce_n = 1'b0;
        step(1);
        chk("R2 lower flag ignored when thr_sel=0", mem_ce_n, 1'b0);
        host_ce_n = 1'b1; fail_lo = 1'b0;
        step(3);
        thr_sel = 1'b1; fail_hi = 1'b1;
        step(3);
        host_ce_n = 1'b0;
        step(1);
        chk("R2 higher flag ignored when thr_sel=1", mem_ce_n, 1'b0);
        host_ce_n = 1'b1;
        step(1);
        fail_lo = 1'b1;
        step(3);
        host_ce_n = 1'b0;
        step(1);
        chk("R2 lower flag protects when thr_sel=1", mem_ce_n, 1'b1);
        recover_check("R8 thr_sel=1");
        thr_sel = 1'b0;
        step(1);
    endtask

    task automatic t_latency;
        host_ce_n = 1'b1; fail_hi = 1'b1;
        step(1);
        host_ce_n = 1'b0;
        step(1);
        chk("R3 fail unseen at edge 2", mem_ce_n, 1'b0);
        host_ce_n = 1'b1;
        step(1);
        chk("R3 fail seen at edge 3", mem_ce_n, 1'b1);
        host_ce_n = 1'b0;
        step(1);
        chk("R4 new access blocked", mem_ce_n, 1'b1);
        step(5);
        chk("R4 still blocked", mem_ce_n, 1'b1);
        recover_check("R8 after idle fail");
    endtask

    task automatic t_drain;
        host_ce_n = 1'b0;
        step(1);
        fail_hi = 1'b1;
        step(3);
        chk("R5 running access continues", mem_ce_n, 1'b0);
        step(2);
        chk("R5 running access still on", mem_ce_n, 1'b0);
        host_ce_n = 1'b1;
        step(1);
        chk("R5 release ends access", mem_ce_n, 1'b1);
        host_ce_n = 1'b0;
        step(1);
        chk("R5 no restart", mem_ce_n, 1'b1);
        step(3);
        chk("R5 no restart later", mem_ce_n, 1'b1);
        recover_check("R8 after drain");
    endtask

    task automatic t_timeout;
        host_ce_n = 1'b0;
        step(1);
        fail_hi = 1'b1;
        step(2 + WP);
        chk("R6 active on last allowed cycle", mem_ce_n, 1'b0);
        step(1);
        chk("R6 cut off at limit", mem_ce_n, 1'b1);
        step(4);
        chk("R6 stays cut off", mem_ce_n, 1'b1);
        recover_check("R8 after timeout");
    endtask

    task automatic t_battery;
        below_sw = 1'b1;
        step(2);
        chk("R7 bat_sel not yet", bat_sel, 1'b0);
        step(1);
        chk("R7 bat_sel on", bat_sel, 1'b1);
        below_sw = 1'b0;
        step(2);
        chk("R7 bat_sel still on", bat_sel, 1'b1);
        step(1);
        chk("R7 bat_sel off", bat_sel, 1'b0);
    endtask

    task automatic t_recur;
        host_ce_n = 1'b1; fail_hi = 1'b1;
        step(3);
        fail_hi = 1'b0; host_ce_n = 1'b0;
        step(8);
        chk("R8 mid recovery held", mem_ce_n, 1'b1);
        fail_hi = 1'b1;
        step(4);
        chk("R10 locked again", mem_ce_n, 1'b1);
        recover_check("R10 full interval restarts");
        // fail reaches controller on the exact edge where recovery would end
        fail_hi = 1'b1;
        step(3);
        fail_hi = 1'b0; host_ce_n = 1'b0;
        step(REC);
        fail_hi = 1'b1;
        step(3);
        chk("R10 fail wins on final recovery edge", mem_ce_n, 1'b1);
        step(3);
        chk("R10 still locked", mem_ce_n, 1'b1);
        recover_check("R10 after coincidence");
    endtask

    initial begin
        t_reset();
        t_follow();
        t_thresh();
        t_latency();
        t_drain();
        t_timeout();
        t_battery();
        t_recur();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800us;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule